// File: doc/BRIEF.md
# Link Error Rate Speed Downgrade Monitor

This block sits beside a serial link's training state machine and decides when the link is too error-prone to keep running at 5.0 Gbps. It counts one kind of link error, chosen by software. The choices are received packets that fail their LCRC check, or entries into the Recovery state that this port started itself. Counting runs inside fixed, back-to-back monitoring windows whose length is set in microseconds. A 1 µs tick comes from the core clock through a prescaler.

When the count inside one window reaches the programmed threshold, the block latches a downgrade request toward 2.5 Gbps and a mask that removes the higher rate from the advertised rates. It also sets a sticky unreliable-link status bit, and a bandwidth-management status bit unless the link is passing through data-link-down at that moment. The downgrade holds until the link fully retrains, or until software issues a retrain while the target speed is 5.0 Gbps. Counting is suspended while the downgrade is held. After release, a fresh window opens with a zero count.

Top module: `link_err_downgrade`

## Requirements
- R1: After reset, downgrade_o, adv_hi_mask_o, unreliable_sts_o and bw_mgmt_sts_o are all 0.
- R2: While enable_i is 0, no error leads to a downgrade, and the error count and window are cleared.
- R3: err_sel_i = 0 counts only lcrc_err_i pulses; err_sel_i = 1 counts only recov_local_i pulses; the unselected input has no effect.
- R4: If an error is counted in cycle N and this brings the count in the current window to at least threshold_i, then downgrade_o and adv_hi_mask_o are 1 from cycle N+1.
- R5: A window lasts max(period_us_i,1) microseconds of CYC_PER_US clocks each, measured from enable or release. The count returns to zero at the end of each window, and errors counted in one window never add to the next.
- R6: A threshold_i of 0 never produces a downgrade.
- R7: Once set, downgrade_o stays 1 until a cycle with full_retrain_i = 1, or with sw_retrain_i = 1 and target_hi_rate_i = 1. It is 0 from the next cycle. A software retrain with target_hi_rate_i = 0 does not release it.
- R8: Errors arriving while downgrade_o is 1 are not counted. After release, counting starts from zero in a new window.
- R9: unreliable_sts_o is set in the same cycle that downgrade_o rises and is cleared only by sts_clear_i. A detection in the same cycle as sts_clear_i leaves it set.
- R10: bw_mgmt_sts_o is set on detection unless dl_down_i is 1 in the detecting cycle. It is cleared only by sts_clear_i, and detection wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Monitor enable |
| err_sel_i | input | 1 | 0: LCRC errors, 1: local recovery entries |
| threshold_i | input | CNT_W | Errors per window that declare the link unreliable; 0 disables |
| period_us_i | input | PER_W | Window length in microseconds |
| lcrc_err_i | input | 1 | One-cycle LCRC error pulse |
| recov_local_i | input | 1 | One-cycle pulse on port-initiated Recovery entry |
| sts_clear_i | input | 1 | Software clear of both status bits |
| full_retrain_i | input | 1 | Link completed a full retrain |
| sw_retrain_i | input | 1 | Software retrain command |
| target_hi_rate_i | input | 1 | Target link speed is 5.0 Gbps |
| dl_down_i | input | 1 | Link is in data-link-down |
| downgrade_o | output | 1 | Request to drop to 2.5 Gbps |
| adv_hi_mask_o | output | 1 | Remove 5.0 Gbps from advertised rates |
| unreliable_sts_o | output | 1 | Sticky unreliable-link status |
| bw_mgmt_sts_o | output | 1 | Sticky bandwidth-management status |

## Verification
All internal state shows only through the timing of the downgrade. A prescaler or window counter that runs off by one shifts the window boundary. An error pattern placed next to that boundary then triggers one window early or late, within a few microseconds. A count that is not cleared, not frozen, or drawn from the wrong source turns into a spurious or missing downgrade_o the cycle after the offending error. The bench compares all four outputs against an independent cycle model on every clock, so such a divergence surfaces within one cycle of the first visible difference.

// File: rtl/ldm_pkg.sv
`timescale 1ns/1ps
package ldm_pkg;
  typedef enum logic {
    SRC_LCRC  = 1'b0,
    SRC_RECOV = 1'b1
  } err_src_e;

  typedef struct packed {
    logic downgrade;
    logic unreliable;
    logic bw_mgmt;
  } ldm_state_t;
endpackage

// File: rtl/ldm_us_prescaler.sv
`timescale 1ns/1ps
module ldm_us_prescaler #(
  parameter int unsigned CYC_PER_US = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] cnt_q;

  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign tick_o = run_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= '0;
      end
    end else begin : g_count
      assign tick_o = run_i && (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (!run_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ldm_window_timer.sv
`timescale 1ns/1ps
module ldm_window_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_us_i,
  output logic             win_end_o
);
  logic [PER_W-1:0] us_q;
  logic             last_us;

  // a period of 0 behaves as 1 us; >= covers a period lowered mid-window
  always_comb begin
    if (period_us_i <= PER_W'(1)) last_us = 1'b1;
    else                          last_us = (us_q >= period_us_i - 1'b1);
  end

  assign win_end_o = run_i && tick_i && last_us;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        us_q <= '0;
    else if (!run_i)    us_q <= '0;
    else if (win_end_o) us_q <= '0;
    else if (tick_i)    us_q <= us_q + 1'b1;
  end
endmodule

// File: rtl/ldm_err_counter.sv
`timescale 1ns/1ps
module ldm_err_counter
  import ldm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             win_end_i,
  input  err_src_e         src_i,
  input  logic             lcrc_err_i,
  input  logic             recov_local_i,
  input  logic [CNT_W-1:0] threshold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ev;

  always_comb begin
    unique case (src_i)
      SRC_LCRC:  ev = lcrc_err_i;
      SRC_RECOV: ev = recov_local_i;
      default:   ev = 1'b0;
    endcase
  end

  // saturating add
  assign cnt_nxt = (ev && (cnt_q != '1)) ? cnt_q + 1'b1 : cnt_q;
  assign hit_o   = run_i && (threshold_i != '0) && (cnt_nxt >= threshold_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (win_end_i) cnt_q <= '0;
    else                cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/ldm_speed_latch.sv
`timescale 1ns/1ps
module ldm_speed_latch
  import ldm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       full_retrain_i,
  input  logic       sw_retrain_i,
  input  logic       target_hi_rate_i,
  input  logic       dl_down_i,
  input  logic       sts_clear_i,
  output ldm_state_t state_o
);
  ldm_state_t st_q, st_d;
  logic       release_req;

  assign release_req = full_retrain_i || (sw_retrain_i && target_hi_rate_i);

  always_comb begin
    st_d = st_q;
    if (st_q.downgrade) begin
      if (release_req) st_d.downgrade = 1'b0;
    end else if (hit_i) begin
      st_d.downgrade = 1'b1;
    end
    // hardware set takes priority over software clear
    if (hit_i)            st_d.unreliable = 1'b1;
    else if (sts_clear_i) st_d.unreliable = 1'b0;
    if (hit_i && !dl_down_i) st_d.bw_mgmt = 1'b1;
    else if (sts_clear_i)    st_d.bw_mgmt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/link_err_downgrade.sv
`timescale 1ns/1ps
module link_err_downgrade
  import ldm_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PER_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             err_sel_i,
  input  logic [CNT_W-1:0] threshold_i,
  input  logic [PER_W-1:0] period_us_i,
  input  logic             lcrc_err_i,
  input  logic             recov_local_i,
  input  logic             sts_clear_i,
  input  logic             full_retrain_i,
  input  logic             sw_retrain_i,
  input  logic             target_hi_rate_i,
  input  logic             dl_down_i,
  output logic             downgrade_o,
  output logic             adv_hi_mask_o,
  output logic             unreliable_sts_o,
  output logic             bw_mgmt_sts_o
);
  ldm_state_t       st;
  logic             run;
  logic             tick;
  logic             win_end;
  logic             hit;
  logic [CNT_W-1:0] err_cnt;
  err_src_e         src;

  assign src = err_src_e'(err_sel_i);
  // counting is suspended while a downgrade is held
  assign run = enable_i && !st.downgrade;

  ldm_us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  ldm_window_timer #(.PER_W(PER_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (tick),
    .period_us_i (period_us_i),
    .win_end_o   (win_end)
  );

  ldm_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .win_end_i     (win_end),
    .src_i         (src),
    .lcrc_err_i    (lcrc_err_i),
    .recov_local_i (recov_local_i),
    .threshold_i   (threshold_i),
    .cnt_o         (err_cnt),
    .hit_o         (hit)
  );

  ldm_speed_latch u_latch (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .hit_i            (hit),
    .full_retrain_i   (full_retrain_i),
    .sw_retrain_i     (sw_retrain_i),
    .target_hi_rate_i (target_hi_rate_i),
    .dl_down_i        (dl_down_i),
    .sts_clear_i      (sts_clear_i),
    .state_o          (st)
  );

  assign downgrade_o      = st.downgrade;
  assign adv_hi_mask_o    = st.downgrade;
  assign unreliable_sts_o = st.unreliable;
  assign bw_mgmt_sts_o    = st.bw_mgmt;
endmodule

// File: rtl/ldm_checker.sv
`timescale 1ns/1ps
module ldm_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [CNT_W-1:0] threshold_i,
  input logic             full_retrain_i,
  input logic             sw_retrain_i,
  input logic             target_hi_rate_i,
  input logic             dl_down_i,
  input logic             sts_clear_i,
  input logic             downgrade_o,
  input logic             unreliable_sts_o,
  input logic             bw_mgmt_sts_o,
  input logic [CNT_W-1:0] err_cnt
);
  assert_no_dg_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !downgrade_o) |=> !downgrade_o);

  assert_thr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (threshold_i == '0 && !downgrade_o) |=> !downgrade_o);

  assert_dg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (downgrade_o && !full_retrain_i && !(sw_retrain_i && target_hi_rate_i)) |=> downgrade_o);

  assert_dg_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (downgrade_o && full_retrain_i) |=> !downgrade_o);

  assert_cnt_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (downgrade_o && $past(downgrade_o)) |-> (err_cnt == '0));

  assert_uld_on_dg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(downgrade_o) |-> unreliable_sts_o);

  assert_uld_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unreliable_sts_o && !sts_clear_i) |=> unreliable_sts_o);

  assert_bw_dldown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bw_mgmt_sts_o && dl_down_i) |=> !bw_mgmt_sts_o);
endmodule

bind link_err_downgrade ldm_checker #(.CNT_W(CNT_W)) u_ldm_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .threshold_i      (threshold_i),
  .full_retrain_i   (full_retrain_i),
  .sw_retrain_i     (sw_retrain_i),
  .target_hi_rate_i (target_hi_rate_i),
  .dl_down_i        (dl_down_i),
  .sts_clear_i      (sts_clear_i),
  .downgrade_o      (downgrade_o),
  .unreliable_sts_o (unreliable_sts_o),
  .bw_mgmt_sts_o    (bw_mgmt_sts_o),
  .err_cnt          (err_cnt)
);

// File: tb/test_link_err_downgrade.sv
`timescale 1ns/1ps
module test_link_err_downgrade;
  localparam int CYC = 4;
  localparam int CW  = 8;
  localparam int PW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, sel = 0, lcrc = 0, rloc = 0, clr = 0, fret = 0, swr = 0, tgt = 0, dld = 0;
  logic [CW-1:0] thr = '0;
  logic [PW-1:0] per = '0;
  logic dg, mask, uld, bw;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_pre, m_us, m_cnt;
  bit m_dg, m_uld, m_bw;

  always #2.5 clk = ~clk;

  link_err_downgrade #(.CYC_PER_US(CYC), .CNT_W(CW), .PER_W(PW)) i_link_err_downgrade (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .err_sel_i(sel), .threshold_i(thr),
    .period_us_i(per), .lcrc_err_i(lcrc), .recov_local_i(rloc), .sts_clear_i(clr),
    .full_retrain_i(fret), .sw_retrain_i(swr), .target_hi_rate_i(tgt), .dl_down_i(dld),
    .downgrade_o(dg), .adv_hi_mask_o(mask), .unreliable_sts_o(uld), .bw_mgmt_sts_o(bw));

  function automatic bit window_done(int us, int p);
    return (p <= 1) ? 1'b1 : (us >= p - 1);
  endfunction

  function automatic int sat_inc(int c, bit e);
    return (e && c < (1 << CW) - 1) ? c + 1 : c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_us = 0; m_cnt = 0; m_dg = 0; m_uld = 0; m_bw = 0;
    end else begin
      bit run, tick, wend, ev, hit;
      int nxt;
      run  = en && !m_dg;
      tick = run && (m_pre == CYC - 1);
      wend = tick && window_done(m_us, per);
      ev   = sel ? rloc : lcrc;
      nxt  = sat_inc(m_cnt, ev);
      hit  = run && (thr != 0) && (nxt >= thr);
      m_pre = !run ? 0 : (m_pre == CYC - 1 ? 0 : m_pre + 1);
      m_us  = !run ? 0 : (wend ? 0 : (tick ? m_us + 1 : m_us));
      m_cnt = (!run || wend) ? 0 : nxt;
      if (m_dg) begin
        if (fret || (swr && tgt)) m_dg = 0;
      end else if (hit) m_dg = 1;
      if (hit) m_uld = 1; else if (clr) m_uld = 0;
      if (hit && !dld) m_bw = 1; else if (clr) m_bw = 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 downgrade_o", dg, m_dg);
    chk("R4 adv_hi_mask_o", mask, m_dg);
    chk("R9 unreliable_sts_o", uld, m_uld);
    chk("R10 bw_mgmt_sts_o", bw, m_bw);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic err(input bit use_recov, input int gap);
    @(negedge clk);
    if (use_recov) rloc = 1; else lcrc = 1;
    @(negedge clk);
    rloc = 0; lcrc = 0;
    cyc(gap);
  endtask

  task automatic full_rt();
    @(negedge clk); fret = 1;
    @(negedge clk); fret = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1 reset values
    chk("R1 downgrade", dg, 0); chk("R1 mask", mask, 0);
    chk("R1 uld", uld, 0);      chk("R1 bw", bw, 0);

    // R2 disabled: errors ignored
    thr = 1; per = 20; sel = 0; en = 0;
    repeat (6) err(0, 1);
    chk("R2 no downgrade while disabled", dg, 0);

    // R3 wrong source ignored
    en = 1; thr = 3; sel = 0;
    repeat (5) err(1, 1);
    chk("R3 recovery ignored in LCRC mode", dg, 0);
    sel = 1;
    repeat (5) err(0, 1);
    chk("R3 LCRC ignored in recovery mode", dg, 0);
    en = 0; cyc(2); en = 1;
    repeat (3) err(1, 0);
    chk("R3 recovery counted", dg, 1);
    chk("R9 uld after detection", uld, 1);
    full_rt(); cyc(1);
    chk("R7 full retrain releases", dg, 0);

    // R5 errors spread across windows: per=2 -> 8 cycles, one error per 5 cycles
    sel = 0; thr = 3; per = 2; en = 0; cyc(1); en = 1;
    repeat (12) err(0, 3);
    chk("R5 spread errors do not trigger", dg, 0);

    // R6 threshold zero
    thr = 0;
    repeat (10) err(0, 0);
    chk("R6 threshold zero never triggers", dg, 0);

    // R7 sw retrain without high target keeps downgrade
    thr = 2; per = 50; en = 0; cyc(1); en = 1;
    err(0, 0); err(0, 0);
    chk("R4 detection at threshold", dg, 1);
    @(negedge clk); swr = 1; tgt = 0;
    @(negedge clk); swr = 0;
    chk("R7 retrain to low target holds", dg, 1);
    // R8 errors while downgraded are not counted
    repeat (5) err(0, 0);
    @(negedge clk); swr = 1; tgt = 1;
    @(negedge clk); swr = 0; tgt = 0;
    chk("R7 retrain to high target releases", dg, 0);
    err(0, 2);
    chk("R8 fresh count after release", dg, 0);

    // R9 / R10 clear, and detection during dl_down
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk("R9 clear drops uld", uld, 0);
    chk("R10 clear drops bw", bw, 0);
    dld = 1; err(0, 0); dld = 0;
    chk("R10 no bw during dl_down", bw, 0);
    chk("R9 uld set during dl_down", uld, 1);
    full_rt();
    // detection wins over clear
    err(0, 0);
    @(negedge clk); lcrc = 1; clr = 1;
    @(negedge clk); lcrc = 0; clr = 0;
    chk("R9 set wins over clear", uld, 1);
    chk("R10 set wins over clear", bw, 1);
    full_rt();

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (i % 250 == 0) begin
        thr = CW'($urandom_range(0, 6));
        per = PW'($urandom_range(0, 6));
        sel = 1'($urandom_range(0, 1));
      end
      en   = ($urandom_range(0, 99) < 92);
      lcrc = ($urandom_range(0, 5) == 0);
      rloc = ($urandom_range(0, 5) == 0);
      fret = ($urandom_range(0, 149) == 0);
      swr  = ($urandom_range(0, 79) == 0);
      tgt  = 1'($urandom_range(0, 1));
      dld  = ($urandom_range(0, 9) == 0);
      clr  = ($urandom_range(0, 59) == 0);
    end
    @(negedge clk);
    {en, lcrc, rloc, fret, swr, tgt, dld, clr} = '0;
    cyc(3);
    finish_run();
  end
endmodule